// File: doc/BRIEF.md
# Ordered-Transfer Interface Controller

This controller links a non-pipelined processor to a set of hardware modules without decoding bus addresses. The full sequence of processor-to-module transfers is fixed before the chip is built. It is stored as a parameter table. A pointer walks the table. Each processor bus access is matched against the entry under the pointer. The controller then pulses the input-latch or output-latch enable that the entry names.

A write to a module fires the input-enable of the named latch. A read must wait until the target module reports completion. While it waits, the processor is held with a stall signal. Once completion is seen, the controller fires the output-enable of the named latch. The pointer moves on after every finished transfer. After the last entry it wraps to entry 0, so the schedule can run again. If an access has the wrong direction for the current entry, the controller sets a sticky error flag. That access is then dropped.

Top module: `xfer_order_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every strobe, `stall_o` and `seq_err_o`, and returns the pointer to entry 0.
- R2: The table holds entry k at bits [k*EW +: EW], where EW = 1 + module-field width + latch-field width. Each entry is packed as {dir, module, latch}, with dir 0 = write and dir 1 = read. A write request that matches the current entry pulses `ie_o[module*LATCH_PER_MOD + latch]` in the cycle after the request.
- R3: A matching read request whose target `done_i` bit is high in the request cycle pulses the matching `oe_o` bit in the next cycle. `stall_o` stays low.
- R4: A matching read request whose target `done_i` bit is low raises `stall_o` from the next cycle. `stall_o` stays high until the cycle after `done_i` of that module is seen high. In that same cycle the matching `oe_o` bit pulses and `stall_o` falls.
- R5: While `stall_o` is high, any `bus_req` is ignored: it produces no strobe and does not move the pointer.
- R6: The pointer advances by one on each completed transfer, meaning each strobe. After entry ORDER_DEPTH-1 it wraps to entry 0.
- R7: A request whose direction (`bus_wr` = 1 for write) disagrees with the current entry sets `seq_err_o` in the next cycle. It produces no strobe and leaves the pointer in place.
- R8: Each strobe lasts a single clock cycle, and at most one bit of `ie_o` and `oe_o` together is high in any cycle.
- R9: Once set, `seq_err_o` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Processor access request, one cycle per access |
| bus_wr | input | 1 | Access direction: 1 write, 0 read |
| done_i | input | NUM_MOD | Completion flag of each module |
| ie_o | output | NUM_MOD*LATCH_PER_MOD | Input-latch enable strobes |
| oe_o | output | NUM_MOD*LATCH_PER_MOD | Output-latch enable strobes |
| stall_o | output | 1 | Processor stall while a read waits for completion |
| seq_err_o | output | 1 | Sticky direction-mismatch flag |

## Verification
Two events can land on the same clock edge:
- A new processor request can arrive in the very cycle a stalled read sees its module complete.
- A read request can arrive in the cycle its module's completion is already high.

The bench provokes the first case by pulsing `bus_req` repeatedly during a stall, including on the edge where `done_i` rises. The rule for that case is that the stall release fires the waiting read's output strobe. The coincident request is dropped, and the next table entry is left untouched for the following access. For the second case, the bench raises `done_i` together with `bus_req`. The rule is an immediate output strobe with no stall. A behavioural reference model compares all outputs every cycle.

// File: rtl/xoc_pkg.sv
package xoc_pkg;

  typedef enum logic {
    XFER_WR = 1'b0,
    XFER_RD = 1'b1
  } xfer_dir_e;

  // Flat latch number of (module, latch) pair.
  function automatic int flat_idx(input int mod, input int lat, input int lat_per_mod);
    return mod * lat_per_mod + lat;
  endfunction

  // Next order position with wrap-around.
  function automatic int wrap_next(input int pos, input int depth);
    return (pos >= depth - 1) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/xoc_entry_sel.sv
module xoc_entry_sel
  import xoc_pkg::*;
#(
  parameter int NUM_MOD       = 4,
  parameter int LATCH_PER_MOD = 2,
  parameter int ORDER_DEPTH   = 8,
  parameter int MOD_W         = 2,
  parameter int LAT_W         = 1,
  parameter int PTR_W         = 3,
  parameter int IDX_W         = 3,
  localparam int ENTRY_W      = 1 + MOD_W + LAT_W,
  parameter logic [ORDER_DEPTH*ENTRY_W-1:0] ORDER_TABLE = '0
) (
  input  logic [PTR_W-1:0] ptr_i,
  output xfer_dir_e        dir_o,
  output logic [MOD_W-1:0] mod_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [ENTRY_W-1:0] entry;
  logic [LAT_W-1:0]   lat;

  always_comb begin
    entry = ORDER_TABLE[int'(ptr_i)*ENTRY_W +: ENTRY_W];
    dir_o = xfer_dir_e'(entry[ENTRY_W-1]);
    mod_o = entry[LAT_W +: MOD_W];
    lat   = entry[LAT_W-1:0];
    idx_o = IDX_W'(flat_idx(int'(mod_o), int'(lat), LATCH_PER_MOD));
  end

endmodule

// File: rtl/xoc_strobe_dec.sv
module xoc_strobe_dec #(
  parameter int NUM_LATCH = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 fire_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_LATCH-1:0] vec_o
);

  for (genvar g = 0; g < NUM_LATCH; g++) begin : g_bit
    assign vec_o[g] = fire_i && (idx_i == IDX_W'(g));
  end

endmodule

// File: rtl/xfer_order_ctrl.sv
module xfer_order_ctrl
  import xoc_pkg::*;
#(
  parameter int NUM_MOD       = 4,
  parameter int LATCH_PER_MOD = 2,
  parameter int ORDER_DEPTH   = 8,
  localparam int MOD_W        = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1,
  localparam int LAT_W        = (LATCH_PER_MOD > 1) ? $clog2(LATCH_PER_MOD) : 1,
  localparam int ENTRY_W      = 1 + MOD_W + LAT_W,
  parameter logic [ORDER_DEPTH*ENTRY_W-1:0] ORDER_TABLE = '0
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               bus_req,
  input  logic                               bus_wr,
  input  logic [NUM_MOD-1:0]                 done_i,
  output logic [NUM_MOD*LATCH_PER_MOD-1:0]   ie_o,
  output logic [NUM_MOD*LATCH_PER_MOD-1:0]   oe_o,
  output logic                               stall_o,
  output logic                               seq_err_o
);

  localparam int PTR_W     = (ORDER_DEPTH > 1) ? $clog2(ORDER_DEPTH) : 1;
  localparam int NUM_LATCH = NUM_MOD * LATCH_PER_MOD;
  localparam int IDX_W     = (NUM_LATCH > 1) ? $clog2(NUM_LATCH) : 1;
  localparam logic [PTR_W-1:0] LAST_POS = PTR_W'(ORDER_DEPTH - 1);

  logic [PTR_W-1:0]     ptr_q;
  logic                 waiting_q;
  logic                 err_q;
  logic [NUM_LATCH-1:0] ie_q, oe_q;

  xfer_dir_e            ent_dir;
  logic [MOD_W-1:0]     ent_mod;
  logic [IDX_W-1:0]     ent_idx;

  xoc_entry_sel #(
    .NUM_MOD(NUM_MOD), .LATCH_PER_MOD(LATCH_PER_MOD), .ORDER_DEPTH(ORDER_DEPTH),
    .MOD_W(MOD_W), .LAT_W(LAT_W), .PTR_W(PTR_W), .IDX_W(IDX_W),
    .ORDER_TABLE(ORDER_TABLE)
  ) u_sel (
    .ptr_i(ptr_q), .dir_o(ent_dir), .mod_o(ent_mod), .idx_o(ent_idx)
  );

  // Named internal events, used by the assertions below.
  logic tgt_done, accept, dir_bad, fire_wr, fire_rd_now, go_wait, fire_rd_late, fire_rd, advance;

  always_comb begin
    tgt_done     = done_i[ent_mod];
    accept       = bus_req && !waiting_q;
    dir_bad      = accept && (bus_wr == (ent_dir == XFER_RD));
    fire_wr      = accept && bus_wr && (ent_dir == XFER_WR);
    fire_rd_now  = accept && !bus_wr && (ent_dir == XFER_RD) && tgt_done;
    go_wait      = accept && !bus_wr && (ent_dir == XFER_RD) && !tgt_done;
    fire_rd_late = waiting_q && tgt_done;
    fire_rd      = fire_rd_now || fire_rd_late;
    advance      = fire_wr || fire_rd;
  end

  logic [NUM_LATCH-1:0] ie_dec, oe_dec;

  xoc_strobe_dec #(.NUM_LATCH(NUM_LATCH), .IDX_W(IDX_W)) u_ie_dec (
    .fire_i(fire_wr), .idx_i(ent_idx), .vec_o(ie_dec)
  );

  xoc_strobe_dec #(.NUM_LATCH(NUM_LATCH), .IDX_W(IDX_W)) u_oe_dec (
    .fire_i(fire_rd), .idx_i(ent_idx), .vec_o(oe_dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      waiting_q <= 1'b0;
      err_q     <= 1'b0;
      ie_q      <= '0;
      oe_q      <= '0;
    end else begin
      ie_q      <= ie_dec;
      oe_q      <= oe_dec;
      waiting_q <= go_wait || (waiting_q && !tgt_done);
      err_q     <= err_q || dir_bad;
      if (advance) ptr_q <= PTR_W'(wrap_next(int'(ptr_q), ORDER_DEPTH));
    end
  end

  assign ie_o      = ie_q;
  assign oe_o      = oe_q;
  assign stall_o   = waiting_q;
  assign seq_err_o = err_q;

  // R8: one strobe at most
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ie_q, oe_q}));

  // R2: input strobe only after an accepted write
  a_r2_ie_after_write: assert property (@(posedge clk) disable iff (rst)
    (|ie_q) |-> $past(fire_wr));

  // R3: output strobe only after a released read
  a_r3_oe_after_read: assert property (@(posedge clk) disable iff (rst)
    (|oe_q) |-> $past(fire_rd));

  // R4: stall holds until completion
  a_r4_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (waiting_q && !tgt_done) |=> stall_o);

  // R4: release drops stall and strobes
  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (waiting_q && tgt_done) |=> (!stall_o && (|oe_o)));

  // R5: requests during stall ignored
  a_r5_stall_ignores: assert property (@(posedge clk) disable iff (rst)
    (waiting_q && !tgt_done) |=> ($stable(ptr_q) && !(|ie_o) && !(|oe_o)));

  // R6: wrap after last entry
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (advance && ptr_q == LAST_POS) |=> (ptr_q == '0));

  // R7: mismatch gives no strobe and holds pointer
  a_r7_mismatch: assert property (@(posedge clk) disable iff (rst)
    dir_bad |=> (seq_err_o && $stable(ptr_q) && !(|{ie_q, oe_q})));

  // R9: sticky error
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    seq_err_o |=> seq_err_o);

endmodule

// File: tb/tb_xfer_order_ctrl.sv
module tb_xfer_order_ctrl;

  localparam int NM = 4;
  localparam int LP = 2;
  localparam int D  = 6;
  localparam int NL = NM * LP;
  // entries {dir, mod[1:0], lat}: dir 0 write, 1 read
  localparam logic [D*4-1:0] TBL = {
    4'b1_01_0,   // e5 R m1 l0
    4'b1_10_0,   // e4 R m2 l0
    4'b0_11_0,   // e3 W m3 l0
    4'b1_00_1,   // e2 R m0 l1
    4'b0_01_1,   // e1 W m1 l1
    4'b0_00_0    // e0 W m0 l0
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_req = 1'b0;
  logic bus_wr = 1'b0;
  logic [NM-1:0] done_i = '0;
  logic [NL-1:0] ie_o, oe_o;
  logic stall_o, seq_err_o;

  xfer_order_ctrl #(.NUM_MOD(NM), .LATCH_PER_MOD(LP), .ORDER_DEPTH(D), .ORDER_TABLE(TBL)) dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr), .done_i(done_i),
    .ie_o(ie_o), .oe_o(oe_o), .stall_o(stall_o), .seq_err_o(seq_err_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // Reference model: schedule as plain integer lists
  int t_rd [D] = '{0, 0, 1, 0, 1, 1};
  int t_mod[D] = '{0, 1, 0, 3, 2, 1};
  int t_lat[D] = '{0, 1, 1, 0, 0, 0};
  int m_pos = 0, m_ie = -1, m_oe = -1;
  bit m_wait = 0, m_err = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_wait = 0; m_err = 0; m_ie = -1; m_oe = -1;
    end else begin
      int n;
      n = t_mod[m_pos] * LP + t_lat[m_pos];
      m_ie = -1; m_oe = -1;
      if (m_wait) begin
        if (done_i[t_mod[m_pos]]) begin
          m_oe = n; m_wait = 0; m_pos = (m_pos + 1) % D;
        end
      end else if (bus_req) begin
        if (bus_wr == (t_rd[m_pos] == 1)) m_err = 1;
        else if (bus_wr) begin m_ie = n; m_pos = (m_pos + 1) % D; end
        else if (done_i[t_mod[m_pos]]) begin m_oe = n; m_pos = (m_pos + 1) % D; end
        else m_wait = 1;
      end
    end
  end

  function automatic logic [NL-1:0] one_at(input int k);
    logic [NL-1:0] v = '0;
    if (k >= 0) v[k] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input string what, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "ie_o", ie_o, one_at(m_ie));
      chk(cur_req, "oe_o", oe_o, one_at(m_oe));
      chk(cur_req, "stall_o", NL'(stall_o), NL'(m_wait));
      chk(cur_req, "seq_err_o", NL'(seq_err_o), NL'(m_err));
    end
  end

  task automatic step(input bit req, input bit wr);
    @(negedge clk);
    bus_req = req;
    bus_wr  = wr;
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    step(0, 0);
    step(0, 0);
    // R2/R3/R6: whole schedule back to back with completion high
    done_i = '1;
    cur_req = "R2";
    step(1, 1); step(1, 1);
    cur_req = "R3";
    step(1, 0);
    step(1, 1);
    step(1, 0); step(1, 0);
    cur_req = "R6";
    step(1, 1);            // wrapped to e0
    step(1, 1);            // e1
    step(0, 0);
    // R4/R5: e2 read with completion low
    done_i = '0;
    cur_req = "R4";
    step(1, 0);
    cur_req = "R5";
    step(1, 1); step(1, 0); step(0, 0);
    done_i[0] = 1'b1;      // completion coincides with a request
    step(1, 1);
    step(0, 0);
    cur_req = "R5";
    step(1, 1);            // e3 write proceeds after release
    cur_req = "R3";
    done_i = 4'b0100;      // e4 completion high with request
    step(1, 0);
    done_i = '0;
    cur_req = "R4";
    step(1, 0);            // e5 stalls
    step(0, 0); step(0, 0);
    done_i[1] = 1'b1;
    step(0, 0);
    done_i = '0;
    step(0, 0);
    // R7/R9: wrong direction at e0
    cur_req = "R7";
    step(1, 0);
    step(0, 0);
    chk("R7", "err after mismatch", NL'(seq_err_o), NL'(1));
    cur_req = "R9";
    step(1, 1);            // e0 write still expected
    step(1, 1);
    step(0, 0); step(0, 0);
    chk("R9", "err still set", NL'(seq_err_o), NL'(1));
    // R1: reset clears error, pointer back to e0
    rst = 1'b1;
    step(0, 0); step(0, 0);
    rst = 1'b0;
    cur_req = "R1";
    step(0, 0);
    chk("R1", "err cleared", NL'(seq_err_o), NL'(0));
    step(1, 1);
    step(0, 0);
    chk("R1", "first write hits e0 latch", ie_o, one_at(0));
    cur_req = "R8";
    step(0, 0); step(0, 0);
    chk("R8", "strobe lasted one cycle", ie_o | oe_o, '0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule